// File: doc/BRIEF.md
# Bus read/write handshake controller

This block sits between a bus master and a slow peripheral and runs a four-phase request/acknowledge exchange on both sides. The master asks for a transfer by raising either a read strobe or a write strobe, never both at once, and waits for a transfer acknowledge. Toward the device the controller raises a device strobe and waits for the device acknowledge. It also drives the enable of the data transceiver that joins the two data buses. Each output changes only after the input events that allow it have been seen.

Reads and writes follow two fixed event orders. In a read, the transceiver is enabled once the device has acknowledged. It is disabled as soon as the master withdraws its strobe. In a write, the transceiver is enabled before the device strobe rises. It is disabled once the device has acknowledged, before the master is told the transfer is done. The sequencer has one extra state after each transfer. That state has the same output values as idle, and the controller stays in it until the device acknowledge has dropped. All inputs are resynchronised to the single clock. A sticky flag reports any input that moves out of turn.

Top module: `bus_hs_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, dev_strobe_o, xcvr_en_o, xfer_ack_o and protocol_error_o are 0, and the controller is idle.
- R2: An input change takes effect on the third rising clock edge after it is applied, for the default two synchronizer stages. For example, dev_strobe_o rises on the third edge after rd_strobe_i rises, and not on the second.
- R3: In a read, dev_strobe_o rises first and xcvr_en_o stays 0 until dev_ack_i has been seen high. Then xcvr_en_o rises, and xfer_ack_o rises one cycle later.
- R4: When rd_strobe_i drops after xfer_ack_o, xcvr_en_o falls first while dev_strobe_o and xfer_ack_o stay 1. One cycle later, dev_strobe_o and xfer_ack_o both fall.
- R5: In a write, xcvr_en_o rises first and dev_strobe_o rises one cycle later. Once dev_ack_i is seen high, xcvr_en_o falls, and xfer_ack_o rises one cycle after that. xcvr_en_o and xfer_ack_o never rise in the same cycle.
- R6: When wr_strobe_i drops after xfer_ack_o, dev_strobe_o and xfer_ack_o both fall together.
- R7: After a transfer, a new strobe is ignored and no output rises until dev_ack_i has been seen low. One cycle after that, a pending strobe starts the next cycle.
- R8: If both strobes are high at the same time, protocol_error_o is set and no transfer starts.
- R9: If the active strobe drops before xfer_ack_o has risen, protocol_error_o is set.
- R10: If dev_ack_i is high while the device strobe has not yet been raised, protocol_error_o is set. It is also set if dev_ack_i falls while the device strobe is still held.
- R11: protocol_error_o stays 1 until reset and does not stop the sequencer.
- R12: xfer_ack_o is high only while dev_strobe_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_strobe_i | input | 1 | Master read request |
| wr_strobe_i | input | 1 | Master write request |
| dev_ack_i | input | 1 | Device acknowledge |
| dev_strobe_o | output | 1 | Device request |
| xcvr_en_o | output | 1 | Data transceiver enable |
| xfer_ack_o | output | 1 | Transfer acknowledge to the master |
| protocol_error_o | output | 1 | Sticky out-of-order input flag |

## Verification
Two events can land in the same cycle. One is a normal sequencer step. The other is the error monitor setting its flag on the same synchronised inputs. This case is provoked by dropping a strobe while the controller waits on the device, and by holding both strobes at once. It is judged by checking that the flag rises on the exact edge where an output step would fall, and that no spurious output change happens there. The cycle-exact samples also confirm that xcvr_en_o and xfer_ack_o never move together. The one exception is the paired release edge, where dev_strobe_o and xfer_ack_o fall at the same time.

// File: rtl/bus_hs_pkg.sv
package bus_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_REQ  = 4'd1,
    ST_RD_DATA = 4'd2,
    ST_RD_ACK  = 4'd3,
    ST_RD_DROP = 4'd4,
    ST_WR_EN   = 4'd5,
    ST_WR_REQ  = 4'd6,
    ST_WR_DONE = 4'd7,
    ST_WR_ACK  = 4'd8,
    ST_RELEASE = 4'd9
  } hs_state_e;

  typedef struct packed {
    logic strobe;
    logic en;
    logic xack;
  } hs_out_t;

  function automatic hs_out_t hs_decode(hs_state_e st);
    hs_out_t o;
    o = '0;
    unique case (st)
      ST_RD_REQ:  o.strobe = 1'b1;
      ST_RD_DATA: begin o.strobe = 1'b1; o.en = 1'b1; end
      ST_RD_ACK:  begin o.strobe = 1'b1; o.en = 1'b1; o.xack = 1'b1; end
      ST_RD_DROP: begin o.strobe = 1'b1; o.xack = 1'b1; end
      ST_WR_EN:   o.en = 1'b1;
      ST_WR_REQ:  begin o.strobe = 1'b1; o.en = 1'b1; end
      ST_WR_DONE: o.strobe = 1'b1;
      ST_WR_ACK:  begin o.strobe = 1'b1; o.xack = 1'b1; end
      default:    o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/bus_hs_sync.sv
module bus_hs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bus_hs_seq.sv
module bus_hs_seq
  import bus_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_i,
  input  logic      wr_i,
  input  logic      ack_i,
  output hs_state_e state_o,
  output hs_out_t   out_o
);

  hs_state_e state_q, state_d;
  hs_out_t   out_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rd_i && !wr_i)      state_d = ST_RD_REQ;
        else if (wr_i && !rd_i) state_d = ST_WR_EN;
      end
      ST_RD_REQ:  if (ack_i) state_d = ST_RD_DATA;
      ST_RD_DATA: state_d = ST_RD_ACK;
      ST_RD_ACK:  if (!rd_i) state_d = ST_RD_DROP;
      ST_RD_DROP: state_d = ST_RELEASE;
      ST_WR_EN:   state_d = ST_WR_REQ;
      ST_WR_REQ:  if (ack_i) state_d = ST_WR_DONE;
      ST_WR_DONE: state_d = ST_WR_ACK;
      ST_WR_ACK:  if (!wr_i) state_d = ST_RELEASE;
      ST_RELEASE: if (!ack_i) state_d = ST_IDLE;  // same outputs as idle
      default:    state_d = ST_IDLE;
    endcase
  end

  // outputs registered from next state: same edge as the state step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      out_q   <= hs_decode(state_d);
    end
  end

  assign state_o = state_q;
  assign out_o   = out_q;

endmodule

// File: rtl/bus_hs_err_mon.sv
module bus_hs_err_mon
  import bus_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  hs_state_e state_i,
  input  logic      rd_i,
  input  logic      wr_i,
  input  logic      ack_i,
  output logic      err_o
);

  logic both_strobes, early_drop, ack_early, ack_lost, viol;
  logic err_q;

  always_comb begin
    both_strobes = rd_i && wr_i;
    early_drop   = 1'b0;
    ack_early    = 1'b0;
    ack_lost     = 1'b0;
    unique case (state_i)
      ST_RD_REQ, ST_RD_DATA:            early_drop = !rd_i;
      ST_WR_EN, ST_WR_REQ, ST_WR_DONE:  early_drop = !wr_i;
      default: ;
    endcase
    unique case (state_i)
      ST_IDLE, ST_WR_EN: ack_early = ack_i;
      ST_RD_DATA, ST_RD_ACK, ST_RD_DROP, ST_WR_DONE, ST_WR_ACK: ack_lost = !ack_i;
      default: ;
    endcase
    viol = both_strobes | early_drop | ack_early | ack_lost;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_q | viol;
  end

  assign err_o = err_q;

endmodule

// File: rtl/bus_hs_ctrl.sv
module bus_hs_ctrl
  import bus_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_strobe_i,
  input  logic wr_strobe_i,
  input  logic dev_ack_i,
  output logic dev_strobe_o,
  output logic xcvr_en_o,
  output logic xfer_ack_o,
  output logic protocol_error_o
);

  localparam int unsigned NUM_IN = 3;

  logic [NUM_IN-1:0] raw_in, syn_in;
  hs_state_e         state;
  hs_out_t           outs;

  assign raw_in = {rd_strobe_i, wr_strobe_i, dev_ack_i};

  bus_hs_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  bus_hs_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (syn_in[2]),
    .wr_i   (syn_in[1]),
    .ack_i  (syn_in[0]),
    .state_o(state),
    .out_o  (outs)
  );

  bus_hs_err_mon u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .rd_i   (syn_in[2]),
    .wr_i   (syn_in[1]),
    .ack_i  (syn_in[0]),
    .err_o  (protocol_error_o)
  );

  assign dev_strobe_o = outs.strobe;
  assign xcvr_en_o    = outs.en;
  assign xfer_ack_o   = outs.xack;

endmodule

// File: rtl/bus_hs_ctrl_chk.sv
module bus_hs_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dev_strobe_o,
  input logic xcvr_en_o,
  input logic xfer_ack_o,
  input logic protocol_error_o
);

  assert_xack_needs_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ack_o |-> dev_strobe_o);

  assert_xack_after_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_ack_o) |-> $past(dev_strobe_o));

  assert_strobe_rise_no_xack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_strobe_o) |-> !xfer_ack_o);

  assert_en_xack_stagger_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(xcvr_en_o) && $rose(xfer_ack_o)));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    protocol_error_o |=> protocol_error_o);

endmodule

bind bus_hs_ctrl bus_hs_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .dev_strobe_o    (dev_strobe_o),
  .xcvr_en_o       (xcvr_en_o),
  .xfer_ack_o      (xfer_ack_o),
  .protocol_error_o(protocol_error_o)
);

// File: tb/bus_hs_ctrl_tb_top.sv
module bus_hs_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic dstb, en, xack, err;
  int   checks = 0, errors = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  bus_hs_ctrl dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .rd_strobe_i     (rd),
    .wr_strobe_i     (wr),
    .dev_ack_i       (ack),
    .dev_strobe_o    (dstb),
    .xcvr_en_o       (en),
    .xfer_ack_o      (xack),
    .protocol_error_o(err)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd = 0; wr = 0; ack = 0;
    wait_n(2);
    chk("R1 strobe in reset", dstb, 0);
    chk("R1 en in reset", en, 0);
    chk("R1 xack in reset", xack, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic test_read();
    rd = 1;
    wait_n(2);
    chk("R2 strobe not yet", dstb, 0);
    wait_n(1);
    chk("R2 strobe rises edge 3", dstb, 1);
    chk("R3 en low before ack", en, 0);
    wait_n(4);
    chk("R3 en waits for ack", en, 0);
    ack = 1;
    wait_n(3);
    chk("R3 en after ack", en, 1);
    chk("R3 xack not yet", xack, 0);
    wait_n(1);
    chk("R3 xack rises", xack, 1);
    rd = 0;
    wait_n(3);
    chk("R4 en falls first", en, 0);
    chk("R4 strobe held", dstb, 1);
    chk("R4 xack held", xack, 1);
    wait_n(1);
    chk("R4 strobe falls", dstb, 0);
    chk("R4 xack falls", xack, 0);
    ack = 0;
    wait_n(3);
    chk("R11 no error on clean read", err, 0);
  endtask

  task automatic test_write();
    wr = 1;
    wait_n(3);
    chk("R5 en first", en, 1);
    chk("R5 strobe not yet", dstb, 0);
    wait_n(1);
    chk("R5 strobe rises", dstb, 1);
    ack = 1;
    wait_n(3);
    chk("R5 en falls after ack", en, 0);
    chk("R5 xack not yet", xack, 0);
    wait_n(1);
    chk("R5 xack rises", xack, 1);
    chk("R5 strobe held", dstb, 1);
    wr = 0;
    wait_n(3);
    chk("R6 strobe falls", dstb, 0);
    chk("R6 xack falls", xack, 0);
    ack = 0;
    wait_n(3);
    chk("R11 no error on clean write", err, 0);
  endtask

  task automatic test_release_hold();
    rd = 1;
    wait_n(3);
    ack = 1;
    wait_n(4);
    rd = 0;
    wait_n(4);
    chk("R7 released", dstb, 0);
    rd = 1;
    wait_n(5);
    chk("R7 strobe ignored while ack high", dstb, 0);
    chk("R7 en ignored", en, 0);
    ack = 0;
    wait_n(3);
    chk("R7 still idle on ack drop edge", dstb, 0);
    wait_n(1);
    chk("R7 pending strobe starts", dstb, 1);
    chk("R7 no error", err, 0);
    do_reset();
  endtask

  task automatic test_both();
    rd = 1; wr = 1;
    wait_n(2);
    chk("R8 err not yet", err, 0);
    wait_n(1);
    chk("R8 err set", err, 1);
    wait_n(2);
    chk("R8 no strobe", dstb, 0);
    chk("R8 no en", en, 0);
    rd = 0; wr = 0;
    wait_n(6);
    chk("R11 err sticky", err, 1);
    do_reset();
    chk("R1 err cleared by reset", err, 0);
  endtask

  task automatic test_early_drop();
    rd = 1;
    wait_n(3);
    chk("R9 read started", dstb, 1);
    rd = 0;
    wait_n(3);
    chk("R9 err on early drop", err, 1);
    chk("R11 strobe still held", dstb, 1);
    do_reset();
  endtask

  task automatic test_ack_order();
    ack = 1;
    wait_n(3);
    chk("R10 err on stray ack", err, 1);
    chk("R10 no strobe", dstb, 0);
    do_reset();
    wr = 1;
    wait_n(4);
    ack = 1;
    wait_n(5);
    chk("R10 no err on proper ack", err, 0);
    ack = 0;
    wait_n(3);
    chk("R10 err on ack lost", err, 1);
    do_reset();
  endtask

  initial begin
    wait_n(3);
    chk("R1 strobe after reset", dstb, 0);
    chk("R1 err after reset", err, 0);
    rst_n = 1'b1;
    wait_n(1);
    test_read();
    test_write();
    test_read();
    test_release_hold();
    test_both();
    test_early_drop();
    test_ack_order();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule